// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This block keeps the protection state of a serial nonvolatile memory: the write enable latch and the three stored protection bits of the status register (a hardware-pin guard enable and a two-bit block-protect code). It receives already decoded command strobes from the serial front end, one strobe per command, each held for a single clock cycle. From them it updates its state, and it reports the status byte that a status read returns.

For every cycle it also says whether a byte write to the presented memory address may go ahead and whether a status write may go ahead. The front end uses these two flags to gate the actual stores. The flags are plain level outputs computed from the current state and the current pin and address inputs, so there is no back-pressure.

The stored protection bits are ordinary registers that reset to zero. They stand in for values that would survive power loss in silicon.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte reads 0x00, and both `mem_wr_ok` and `sr_wr_ok` are 0.
- R2: A `cmd_wren` pulse sets the write enable latch and a `cmd_wrdi` pulse clears it. If both come in the same cycle, the clear wins. The live latch value reads back in status bit 1 from the cycle after the pulse.
- R3: A `wr_end` pulse (chip select rising at the end of a write command) clears the write enable latch. It dominates a `cmd_wren` in the same cycle.
- R4: An accepted `cmd_wrsr` loads data bit 7 into the guard enable (status bit 7) and data bits 3:2 into the block-protect code (status bits 3:2). Status bits 6:4 and 0 always read 0, and the written data never changes the latch in bit 1.
- R5: The block-protect code selects the protected addresses. 00 protects none, 01 protects the top quarter (0x600 to 0x7FF for 11 address bits), 10 protects the top half (0x400 to 0x7FF), and 11 protects every address.
- R6: `mem_wr_ok` is 1 exactly when the latch is set and `mem_addr` lies outside the protected range. `wp_n` never influences it.
- R7: `sr_wr_ok` is 1 exactly when the latch is set and it is not the case that the guard enable is 1 while `wp_n` is 0. With the guard enable at 0, `wp_n` is ignored.
- R8: A `cmd_wrsr` that arrives while `sr_wr_ok` is 0 leaves status bits 7, 3 and 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Set-write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status write strobe, data on `wrsr_data` |
| wrsr_data | input | 8 | Byte carried by the status write |
| wr_end | input | 1 | End of a write command (chip select released) |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| mem_addr | input | ADDR_W | Memory byte address being targeted |
| status_q | output | 8 | Status byte for a status read |
| mem_wr_ok | output | 1 | Memory byte write permitted at `mem_addr` |
| sr_wr_ok | output | 1 | Status write permitted |

## Verification
The two permission flags are combinational, so they depend on the same cycle's `wp_n` and `mem_addr`. The bench checks them 2 ns after it drives inputs on the falling edge, which is before the next rising edge. Every strobe takes effect at the next rising edge, and the status byte is compared 1 ns after that edge, once the registers have settled. A reference model in the bench updates on the same edge, computing its permissions from its state as it stood before the update. This matches how the design gates a status write with the latch value it holds at the strobe.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

  localparam int SR_W        = 8;
  localparam int SR_GUARD_BIT = 7;
  localparam int SR_BPH_BIT  = 3;
  localparam int SR_BPL_BIT  = 2;
  localparam int SR_WEL_BIT  = 1;

  typedef enum logic [1:0] {
    ZONE_NONE    = 2'b00,
    ZONE_QUARTER = 2'b01,
    ZONE_HALF    = 2'b10,
    ZONE_ALL     = 2'b11
  } zone_e;

  typedef struct packed {
    logic  guard;
    zone_e zone;
  } prot_t;

  localparam prot_t PROT_RST = '{guard: 1'b0, zone: ZONE_NONE};

  function automatic logic [SR_W-1:0] sr_pack(prot_t p, logic wel);
    logic [SR_W-1:0] s;
    s = '0;
    s[SR_GUARD_BIT] = p.guard;
    s[SR_BPH_BIT]   = p.zone[1];
    s[SR_BPL_BIT]   = p.zone[0];
    s[SR_WEL_BIT]   = wel;
    return s;
  endfunction

endpackage

// File: rtl/sr_guard_wel.sv
module sr_guard_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic end_i,
  output logic wel_o
);

  logic wel_d;

  // clear sources dominate the set
  always_comb begin
    wel_d = wel_o;
    if (end_i || clr_i) wel_d = 1'b0;
    else if (set_i)     wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_o <= 1'b0;
    else        wel_o <= wel_d;
  end

endmodule

// File: rtl/sr_guard_bits.sv
module sr_guard_bits
  import sr_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  logic   guard_i,
  input  logic [1:0] zone_i,
  output prot_t  prot_o
);

  prot_t prot_d;

  always_comb begin
    prot_d = prot_o;
    if (load_i) begin
      prot_d.guard = guard_i;
      prot_d.zone  = zone_e'(zone_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_o <= PROT_RST;
    else        prot_o <= prot_d;
  end

endmodule

// File: rtl/sr_guard_range.sv
module sr_guard_range
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  zone_e             zone_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  localparam int TOP = ADDR_W - 1;

  logic [1:0] quad;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign quad = addr_i[TOP -: 2];
    end else begin : g_narrow
      assign quad = {addr_i[0], addr_i[0]};
    end
  endgenerate

  always_comb begin
    unique case (zone_i)
      ZONE_NONE:    hit_o = 1'b0;
      ZONE_QUARTER: hit_o = (quad == 2'b11);
      ZONE_HALF:    hit_o = quad[1];
      ZONE_ALL:     hit_o = 1'b1;
      default:      hit_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              wr_end,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        status_q,
  output logic              mem_wr_ok,
  output logic              sr_wr_ok
);

  logic  wel;
  prot_t prot;
  logic  zone_hit;
  logic  pin_lock;
  logic  sr_load;
  logic  unused_fixed;

  // fixed-zero positions of the written byte carry no state
  assign unused_fixed = ^{wrsr_data[6:4], wrsr_data[1:0]};

  sr_guard_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (cmd_wren),
    .clr_i (cmd_wrdi),
    .end_i (wr_end),
    .wel_o (wel)
  );

  assign pin_lock = prot.guard && !wp_n;
  assign sr_wr_ok = wel && !pin_lock;
  assign sr_load  = cmd_wrsr && sr_wr_ok;

  sr_guard_bits u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (sr_load),
    .guard_i (wrsr_data[SR_GUARD_BIT]),
    .zone_i  ({wrsr_data[SR_BPH_BIT], wrsr_data[SR_BPL_BIT]}),
    .prot_o  (prot)
  );

  sr_guard_range #(.ADDR_W(ADDR_W)) u_range (
    .zone_i (prot.zone),
    .addr_i (mem_addr),
    .hit_o  (zone_hit)
  );

  assign mem_wr_ok = wel && !zone_hit;
  assign status_q  = sr_pack(prot, wel);

endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_wrsr,
  input logic [7:0] wrsr_data,
  input logic       wr_end,
  input logic       wp_n,
  input logic [7:0] status_q,
  input logic       mem_wr_ok,
  input logic       sr_wr_ok
);

  a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && !cmd_wrdi && !wr_end) |=> status_q[1]);

  a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrdi |=> !status_q[1]);

  a_r3_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> !status_q[1]);

  a_r4_wrsr_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && sr_wr_ok) |=>
      (status_q[7] == $past(wrsr_data[7]) && status_q[3:2] == $past(wrsr_data[3:2])));

  a_r4_wel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && !cmd_wren && !cmd_wrdi && !wr_end) |=> $stable(status_q[1]));

  a_r8_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && !sr_wr_ok) |=> ($stable(status_q[7]) && $stable(status_q[3:2])));

  a_r6_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[1] |-> !mem_wr_ok);

  a_r5_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[3:2] == 2'b11) |-> !mem_wr_ok);

  a_r7_pin_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[7] && !wp_n) |-> !sr_wr_ok);

  a_r7_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[7] && status_q[1]) |-> sr_wr_ok);

endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wren  (cmd_wren),
  .cmd_wrdi  (cmd_wrdi),
  .cmd_wrsr  (cmd_wrsr),
  .wrsr_data (wrsr_data),
  .wr_end    (wr_end),
  .wp_n      (wp_n),
  .status_q  (status_q),
  .mem_wr_ok (mem_wr_ok),
  .sr_wr_ok  (sr_wr_ok)
);

// File: tb/sim_sr_guard.sv
module sim_sr_guard;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_wren, cmd_wrdi, cmd_wrsr, wr_end, wp_n;
  logic [7:0]    wrsr_data;
  logic [AW-1:0] mem_addr;
  logic [7:0]    status_q;
  logic          mem_wr_ok, sr_wr_ok;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic       m_wel, m_guard;
  logic [1:0] m_bp;

  always #10 clk = ~clk;

  sr_guard #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .wr_end(wr_end), .wp_n(wp_n),
    .mem_addr(mem_addr), .status_q(status_q), .mem_wr_ok(mem_wr_ok),
    .sr_wr_ok(sr_wr_ok)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic in_zone(logic [1:0] bp, logic [AW-1:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 11'h600;
      2'b10:   return a >= 11'h400;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    return {m_guard, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  // one clock: drive at falling edge, check flags, then status after the rise
  task automatic cyc(logic wren, logic wrdi, logic wrsr, logic [7:0] d,
                     logic wend, logic wp, logic [AW-1:0] a);
    logic e_sr, e_mem;
    @(negedge clk);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr; wrsr_data = d;
    wr_end = wend; wp_n = wp; mem_addr = a;
    #2;
    e_sr  = m_wel && !(m_guard && !wp);
    e_mem = m_wel && !in_zone(m_bp, a);
    chk("R7 sr_wr_ok", sr_wr_ok, e_sr);
    chk("R5/R6 mem_wr_ok", mem_wr_ok, e_mem);
    @(posedge clk);
    if (wrsr && e_sr) begin
      m_guard = d[7];
      m_bp    = d[3:2];
    end
    if (wend || wrdi) m_wel = 1'b0;
    else if (wren)    m_wel = 1'b1;
    #1;
    chk("R2/R3/R4/R8 status", status_q, m_status());
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; wr_end = 0;
    wrsr_data = 8'h00; wp_n = 1'b1; mem_addr = '0;
    m_wel = 0; m_guard = 0; m_bp = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1 reset status", status_q, 8'h00);
    chk("R1 reset mem_wr_ok", mem_wr_ok, 1'b0);
    chk("R1 reset sr_wr_ok", sr_wr_ok, 1'b0);

    // R2: set then clear, clear wins when both arrive
    cyc(1, 0, 0, 8'h00, 0, 1, 11'h000);
    chk("R2 wel set", status_q, 8'h02);
    cyc(1, 1, 0, 8'h00, 0, 1, 11'h000);
    chk("R2 wrdi wins", status_q, 8'h00);
    // R3: end-of-write beats a same-cycle set
    cyc(1, 0, 0, 8'h00, 0, 1, 11'h000);
    cyc(1, 0, 0, 8'h00, 1, 1, 11'h000);
    chk("R3 end clears", status_q, 8'h00);

    // R4: write all ones, fixed bits stay 0, latch untouched by data
    cyc(1, 0, 0, 8'h00, 0, 1, 11'h000);
    cyc(0, 0, 1, 8'hFF, 0, 1, 11'h000);
    chk("R4 wrsr load", status_q, 8'h8E);
    cyc(0, 0, 0, 8'h00, 1, 1, 11'h000);
    chk("R3 end after wrsr", status_q, 8'h8C);

    // R8: guarded and pin low, rejected write keeps bits
    cyc(1, 0, 0, 8'h00, 0, 0, 11'h000);
    cyc(0, 0, 1, 8'h00, 0, 0, 11'h7FF);
    chk("R8 rejected", status_q, 8'h8E);
    chk("R5 all protected", mem_wr_ok, 1'b0);
    // R7: pin high lets it through, setting the quarter zone
    cyc(0, 0, 1, 8'h04, 0, 1, 11'h000);
    chk("R7 pin high accepts", status_q, 8'h06);

    // R5/R6: quarter and half boundaries, wp_n low has no effect on memory
    cyc(0, 0, 0, 8'h00, 0, 0, 11'h5FF);
    chk("R5 quarter below", mem_wr_ok, 1'b1);
    cyc(0, 0, 0, 8'h00, 0, 0, 11'h600);
    chk("R5 quarter edge", mem_wr_ok, 1'b0);
    cyc(0, 0, 1, 8'h08, 0, 0, 11'h3FF);
    chk("R5 half below", mem_wr_ok, 1'b1);
    cyc(0, 0, 0, 8'h00, 0, 1, 11'h400);
    chk("R5 half edge", mem_wr_ok, 1'b0);
    chk("R7 guard off ignores pin", sr_wr_ok, 1'b1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
          8'($urandom), ($urandom % 8) == 0, ($urandom % 2) == 1,
          AW'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule